// File: doc/BRIEF.md
# Group and Crowd Level Encoder

This block converts the target of an interrupt notification into the compact 6-bit level code that a presenter attaches to a pending interrupt. It also reports how many targets the group spans. The target may be a single context, a group of contexts or a crowd of groups. For a group, the encoder counts the run of one bits at the low end of the target index. That count gives the group size as a power of two and the low four bits of the level. For a crowd, the same count taken on the target block number gives a crowd size. That size is mapped onto a two-bit field in the upper part of the level, and only some crowd sizes are accepted.

The block has one register stage. A request is accepted on every clock where the input strobe is high. Its result appears on the outputs one clock later, with an output strobe. Requests that cannot be encoded raise an error flag and return a level and size of zero. The block does not choose a thread inside the group and does not forward the notification.

Top module: `grp_level_enc`

## Requirements
- R1: While reset is high, and on the first clock after it, out_vld, out_level, out_size and out_err are all zero.
- R2: out_vld is high exactly one clock after a clock with in_vld high and is low one clock after in_vld low; a new request is taken on every cycle.
- R3: With in_ignore low and in_crowd low (single target), the result is level 0, size 0, error 0.
- R4: With in_ignore low and in_crowd high, the request is malformed: error 1, level 0, size 0.
- R5: With in_ignore high, let t be the number of consecutive one bits in in_index counted from bit 0 (the position of the lowest zero bit); the size is 2^(t+1).
- R6: For a valid group request, out_level[3:0] equals (t+1) modulo 16, and out_level[5:4] is 0 when in_crowd is low.
- R7: When t is 31 or more, the index is invalid: error 1, level 0, size 0.
- R8: With in_ignore and in_crowd high, let c be the trailing-ones count of in_block plus one; c=1 places 1, c=2 places 2 and c=4 places 3 into out_level[5:4]. The low bits and the size follow R5 and R6.
- R9: Any other crowd value c (3, or 5 and above) is unsupported: error 1, level 0, size 0.
- R10: On a clock with in_vld low, out_level, out_size and out_err keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| in_ignore | input | 1 | Target is a group (low index bits ignored) |
| in_crowd | input | 1 | Target is a crowd of groups |
| in_index | input | 32 | Target index |
| in_block | input | 8 | Target block number |
| out_vld | output | 1 | Result strobe, one clock after in_vld |
| out_level | output | 6 | Encoded level: [5:4] crowd field, [3:0] group field |
| out_size | output | 32 | Group size, 2^(t+1), or 0 |
| out_err | output | 1 | Request could not be encoded |

## Verification
The only state is the single result register, so a fault inside it shows at the ports on the clock after the offending request. A miscounted run of ones gives a size that is off by a power of two and a low level field that disagrees with it. A wrong crowd mapping shows up when block values giving 3 and 4 are sent back to back. A stale enable leaves old results visible after in_vld falls, or lets idle inputs overwrite them. The cases that matter most are the boundaries: run lengths of 15, 30, 31 and 32, and crowd values 3 and 5.

// File: rtl/grp_level_enc_pkg.sv
package grp_level_enc_pkg;
  localparam int LOW_W   = 4;
  localparam int CROWD_W = 2;
  localparam int LEVEL_W = LOW_W + CROWD_W;

  localparam logic [CROWD_W-1:0] CROWD_CODE_2  = 2'd1;
  localparam logic [CROWD_W-1:0] CROWD_CODE_4  = 2'd2;
  localparam logic [CROWD_W-1:0] CROWD_CODE_16 = 2'd3;

  typedef struct packed {
    logic               err;
    logic [LEVEL_W-1:0] level;
  } enc_word_t;
endpackage

// File: rtl/gle_ones_run.sv
module gle_ones_run #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    logic run;
    run   = 1'b1;
    count = '0;
    for (int i = 0; i < W; i++) begin
      if (run && vec[i]) count = count + CW'(1);
      else               run   = 1'b0;
    end
  end
endmodule

// File: rtl/gle_crowd_map.sv
module gle_crowd_map
  import grp_level_enc_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [CW-1:0]      blk_ones,
  output logic [CROWD_W-1:0] field,
  output logic               unsupported
);
  logic [CW:0] crowd_val;
  assign crowd_val = {1'b0, blk_ones} + (CW+1)'(1);

  always_comb begin
    field       = '0;
    unsupported = 1'b0;
    case (crowd_val)
      (CW+1)'(1): field = CROWD_CODE_2;
      (CW+1)'(2): field = CROWD_CODE_4;
      (CW+1)'(4): field = CROWD_CODE_16;
      default:    unsupported = 1'b1;
    endcase
  end
endmodule

// File: rtl/gle_out_reg.sv
module gle_out_reg
  import grp_level_enc_pkg::*;
#(
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  enc_word_t         word_d,
  input  logic [SIZE_W-1:0] size_d,
  output logic              vld_q,
  output enc_word_t         word_q,
  output logic [SIZE_W-1:0] size_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      word_q <= '0;
      size_q <= '0;
    end else begin
      vld_q <= load;
      if (load) begin
        word_q <= word_d;
        size_q <= size_d;
      end
    end
  end
endmodule

// File: rtl/grp_level_enc.sv
module grp_level_enc
  import grp_level_enc_pkg::*;
#(
  parameter int IDX_W     = 32,
  parameter int BLK_W     = 8,
  parameter int SIZE_W    = 32,
  parameter int IDX_LIMIT = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic               in_ignore,
  input  logic               in_crowd,
  input  logic [IDX_W-1:0]   in_index,
  input  logic [BLK_W-1:0]   in_block,
  output logic               out_vld,
  output logic [LEVEL_W-1:0] out_level,
  output logic [SIZE_W-1:0]  out_size,
  output logic               out_err
);
  localparam int TW = $clog2(IDX_W + 1) + 1;
  localparam int BW = $clog2(BLK_W + 1);

  logic [TW-2:0]        idx_ones;
  logic [TW-1:0]        t_wide;
  logic [TW-1:0]        t_plus;
  logic [BW-1:0]        blk_ones;
  logic [CROWD_W-1:0]   crowd_field;
  logic                 crowd_unsup;
  logic                 idx_bad, crowd_bad, mode_bad, err_n, good_grp;
  logic [SIZE_W-1:0]    size_n;
  enc_word_t            word_n, word_q;

  gle_ones_run #(.W(IDX_W), .CW(TW-1)) u_idx_run (
    .vec(in_index), .count(idx_ones));

  gle_ones_run #(.W(BLK_W), .CW(BW)) u_blk_run (
    .vec(in_block), .count(blk_ones));

  gle_crowd_map #(.CW(BW)) u_crowd (
    .blk_ones(blk_ones), .field(crowd_field), .unsupported(crowd_unsup));

  assign t_wide    = {1'b0, idx_ones};
  assign t_plus    = t_wide + TW'(1);
  assign idx_bad   = in_ignore && (32'(t_wide) >= 32'(IDX_LIMIT));
  assign crowd_bad = in_ignore && in_crowd && crowd_unsup;
  assign mode_bad  = !in_ignore && in_crowd;
  assign err_n     = idx_bad || crowd_bad || mode_bad;
  assign good_grp  = in_ignore && !err_n;

  always_comb begin
    word_n.err   = err_n;
    word_n.level = '0;
    size_n       = '0;
    if (good_grp) begin
      word_n.level[LOW_W-1:0] = t_plus[LOW_W-1:0];
      if (in_crowd) word_n.level[LEVEL_W-1:LOW_W] = crowd_field;
      size_n = SIZE_W'(1) << t_plus;
    end
  end

  gle_out_reg #(.SIZE_W(SIZE_W)) u_out (
    .clk(clk), .rst(rst), .load(in_vld), .word_d(word_n), .size_d(size_n),
    .vld_q(out_vld), .word_q(word_q), .size_q(out_size));

  assign out_level = word_q.level;
  assign out_err   = word_q.err;
endmodule

// File: rtl/grp_level_enc_chk.sv
module grp_level_enc_chk #(
  parameter int IDX_W   = 32,
  parameter int BLK_W   = 8,
  parameter int SIZE_W  = 32,
  parameter int LEVEL_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               in_vld,
  input logic               in_ignore,
  input logic               in_crowd,
  input logic [IDX_W-1:0]   in_index,
  input logic [BLK_W-1:0]   in_block,
  input logic               out_vld,
  input logic [LEVEL_W-1:0] out_level,
  input logic [SIZE_W-1:0]  out_size,
  input logic               out_err
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_vld && out_level == '0 && out_size == '0 && !out_err));

  assert_vld_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  assert_vld_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  assert_single_target_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !in_ignore && !in_crowd) |=> (!out_err && out_level == '0 && out_size == '0));

  assert_bad_mode_R4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !in_ignore && in_crowd) |=> out_err);

  assert_size_pow2_R5: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_err) |-> ($countones(out_size) <= 1 && !out_size[0]));

  assert_min_group_R6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_ignore && !in_crowd && !in_index[0]) |=> (out_size == SIZE_W'(2) && out_level == LEVEL_W'(1)));

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_err) |-> (out_level == '0 && out_size == '0));

  assert_crowd_three_R9: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_ignore && in_crowd && in_block[1:0] == 2'b11 && !in_block[2]) |=> out_err);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(out_level) && $stable(out_size) && $stable(out_err)));
endmodule

bind grp_level_enc grp_level_enc_chk #(
  .IDX_W(IDX_W), .BLK_W(BLK_W), .SIZE_W(SIZE_W), .LEVEL_W(grp_level_enc_pkg::LEVEL_W)
) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_ignore(in_ignore), .in_crowd(in_crowd),
  .in_index(in_index), .in_block(in_block), .out_vld(out_vld), .out_level(out_level),
  .out_size(out_size), .out_err(out_err)
);

// File: tb/grp_level_enc_tb.sv
`timescale 1ns/1ps
module grp_level_enc_tb;
  localparam int IDX_W = 32;
  localparam int BLK_W = 8;
  localparam int SIZE_W = 32;
  localparam int LVL_W = 6;
  localparam int VW = 2 + IDX_W + BLK_W + LVL_W + SIZE_W + 1;
  localparam int NV = 17;

  // {ignore, crowd, index, block, exp_level, exp_size, exp_err}
  localparam logic [VW-1:0] VECS [0:NV-1] = '{
    {1'b0, 1'b0, 32'h0000_0007, 8'h00, 6'h00, 32'h0000_0000, 1'b0}, // R3
    {1'b0, 1'b1, 32'h0000_0000, 8'h00, 6'h00, 32'h0000_0000, 1'b1}, // R4
    {1'b1, 1'b0, 32'h0000_0000, 8'h00, 6'h01, 32'h0000_0002, 1'b0}, // R5 t=0
    {1'b1, 1'b0, 32'h0000_0001, 8'h00, 6'h02, 32'h0000_0004, 1'b0}, // R5 t=1
    {1'b1, 1'b0, 32'h0000_00FF, 8'h00, 6'h09, 32'h0000_0200, 1'b0}, // R5 t=8
    {1'b1, 1'b0, 32'h0000_7FFF, 8'h00, 6'h00, 32'h0001_0000, 1'b0}, // R6 wrap t=15
    {1'b1, 1'b0, 32'h3FFF_FFFF, 8'h00, 6'h0F, 32'h8000_0000, 1'b0}, // R6 t=30
    {1'b1, 1'b0, 32'h7FFF_FFFF, 8'h00, 6'h00, 32'h0000_0000, 1'b1}, // R7 t=31
    {1'b1, 1'b0, 32'hFFFF_FFFF, 8'h00, 6'h00, 32'h0000_0000, 1'b1}, // R7 t=32
    {1'b1, 1'b1, 32'h0000_0003, 8'h00, 6'h13, 32'h0000_0008, 1'b0}, // R8 c=1
    {1'b1, 1'b1, 32'h0000_0003, 8'h01, 6'h23, 32'h0000_0008, 1'b0}, // R8 c=2
    {1'b1, 1'b1, 32'h0000_0003, 8'h07, 6'h33, 32'h0000_0008, 1'b0}, // R8 c=4
    {1'b1, 1'b1, 32'h0000_00A5, 8'h05, 6'h22, 32'h0000_0004, 1'b0}, // R8 mixed bits
    {1'b1, 1'b1, 32'h0000_0003, 8'h03, 6'h00, 32'h0000_0000, 1'b1}, // R9 c=3
    {1'b1, 1'b1, 32'h0000_0003, 8'h0F, 6'h00, 32'h0000_0000, 1'b1}, // R9 c=5
    {1'b1, 1'b1, 32'h0000_0003, 8'hFF, 6'h00, 32'h0000_0000, 1'b1}, // R9 c=9
    {1'b1, 1'b1, 32'hFFFF_FFFF, 8'h00, 6'h00, 32'h0000_0000, 1'b1}  // R7 with crowd
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_vld = 1'b0;
  logic              in_ignore = 1'b0;
  logic              in_crowd = 1'b0;
  logic [IDX_W-1:0]  in_index = '0;
  logic [BLK_W-1:0]  in_block = '0;
  logic              out_vld;
  logic [LVL_W-1:0]  out_level;
  logic [SIZE_W-1:0] out_size;
  logic              out_err;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  grp_level_enc u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_ignore(in_ignore), .in_crowd(in_crowd),
    .in_index(in_index), .in_block(in_block), .out_vld(out_vld), .out_level(out_level),
    .out_size(out_size), .out_err(out_err));

  task automatic check_out(input string req, input logic v, input logic [LVL_W-1:0] lvl,
                           input logic [SIZE_W-1:0] sz, input logic e);
    checks++;
    if (out_vld !== v || out_level !== lvl || out_size !== sz || out_err !== e) begin
      fails++;
      $display("FAIL %s: got vld=%b lvl=%h size=%h err=%b, expected vld=%b lvl=%h size=%h err=%b",
               req, out_vld, out_level, out_size, out_err, v, lvl, sz, e);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [VW-1:0] last;
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 1'b0, '0, '0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_out("R1 after release", 1'b0, '0, '0, 1'b0);

    // back-to-back vector walk, R2 latency of one clock
    for (int i = 0; i < NV; i++) begin
      last = VECS[i];
      {in_ignore, in_crowd, in_index, in_block} = last[VW-1:LVL_W+SIZE_W+1];
      in_vld = 1'b1;
      @(negedge clk);
      check_out($sformatf("R2/R5 vector %0d", i), 1'b1, last[LVL_W+SIZE_W:SIZE_W+1],
                last[SIZE_W:1], last[0]);
    end

    // R10: idle cycles with changing inputs keep the last result, R2 strobe drops
    in_vld    = 1'b0;
    in_ignore = 1'b1;
    in_crowd  = 1'b0;
    in_index  = 32'h0000_0000;
    @(negedge clk);
    check_out("R10 idle 1", 1'b0, last[LVL_W+SIZE_W:SIZE_W+1], last[SIZE_W:1], last[0]);
    in_index = 32'h0000_000F;
    @(negedge clk);
    check_out("R10 idle 2", 1'b0, last[LVL_W+SIZE_W:SIZE_W+1], last[SIZE_W:1], last[0]);

    // single request after idle, R2 and R6 low-field only
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    check_out("R6 t=4", 1'b1, 6'h05, 32'h0000_0020, 1'b0);
    @(negedge clk);
    check_out("R2 strobe low", 1'b0, 6'h05, 32'h0000_0020, 1'b0);

    // R1 mid-run reset clears the registers
    in_vld = 1'b1;
    rst    = 1'b1;
    @(negedge clk);
    check_out("R1 mid-run reset", 1'b0, '0, '0, 1'b0);
    rst    = 1'b0;
    in_vld = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule